// File: doc/BRIEF.md
# Cache-Line Lock Snoop Retry Unit

This unit holds an exclusive lock for a bridge that sits between an I/O bus (PCI) and a processor bus. When the I/O side begins a locked access, the unit records the master that issued it. It also records the aligned 32-byte line that contains the access address, by dropping the five low address bits. For example, a locked access at 0x28 claims the line that starts at 0x20.

While the lock is held, two checks run in the same cycle as their request. Every processor-bus address is compared with the stored line, and a match raises a retry. The retry is benign: the unit starts no transfer of its own afterwards. Every I/O-side access from a master other than the recorded owner is also retried, whatever it targets.

The lock ends only when both of two events have happened: an unlock indication, and the completion pulse of the last locked transfer. Until then the snooping goes on.

Top module: `line_lock_retry`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the lock: afterwards `lock_active` is 0 and neither retry output is asserted.
- R2: When no lock is held, a pulse on `lk_start` makes `lock_active` 1 from the next clock edge. The stored line is `lk_addr` with bits [4:0] cleared, and the stored owner is `lk_id`.
- R3: While a lock is held, `cpu_retry` is 1 in the same cycle as `cpu_valid` whenever `cpu_addr[31:5]` equals the stored line. A lock taken at 0x28 therefore retries every address from 0x20 to 0x3F.
- R4: While a lock is held, `cpu_retry` stays 0 for addresses outside the stored line, and in any cycle where `cpu_valid` is 0.
- R5: While a lock is held, `pci_retry` is 1 in the same cycle as `pci_valid` when `pci_id` differs from the stored owner.
- R6: While a lock is held, an access by the stored owner (`pci_id` equal to the owner) gives `pci_retry` 0.
- R7: An unlock pulse on its own does not end the lock. `lock_active` stays 1 and both kinds of retry continue.
- R8: A completion pulse on `lk_done` ends the lock at the next edge only if an unlock has been received earlier. A completion with no unlock before it leaves the lock in place.
- R9: An unlock and a completion arriving in the same cycle end the lock at the next edge.
- R10: A second `lk_start` while a lock is held is ignored: the stored line and the stored owner do not change.
- R11: With no lock held, neither retry output is ever asserted, whatever the address or master ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_start | input | 1 | Pulse: a locked I/O-side access begins |
| lk_addr | input | 32 | Address of the locked access |
| lk_id | input | 4 | Master ID of the locked access |
| lk_unlock | input | 1 | Pulse: unlock indication received |
| lk_done | input | 1 | Pulse: a locked transfer completed successfully |
| cpu_valid | input | 1 | Processor-bus address strobe |
| cpu_addr | input | 32 | Processor-bus address |
| cpu_retry | output | 1 | Retry for the current processor transaction (combinational) |
| pci_valid | input | 1 | I/O-side access strobe |
| pci_id | input | 4 | Master ID of the I/O-side access |
| pci_retry | output | 1 | Retry for the current I/O-side access (combinational) |
| lock_active | output | 1 | A lock is held (locked or waiting for the final completion) |

## Verification
There are two kinds of result, and they are due at different times.

Both retry outputs are combinational. The bench drives each probe half a nanosecond after a rising edge and samples half a nanosecond later, inside the same cycle.

Changes to the lock state are made by one register. They therefore show on `lock_active`, and on the retries that follow, one edge after the pulse that causes them. The bench holds each pulse across exactly one rising edge and checks only after that edge has passed.

// File: rtl/line_lock_pkg.sv
package line_lock_pkg;

    typedef enum logic [1:0] {
        LK_IDLE    = 2'd0,
        LK_HELD    = 2'd1,
        LK_DRAINING = 2'd2
    } lk_state_e;

endpackage

// File: rtl/lock_state_ctl.sv
module lock_state_ctl
    import line_lock_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4,
    parameter int OFS_W  = 5,
    localparam int TAG_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic              unlock_i,
    input  logic              done_i,
    output logic              held_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [ID_W-1:0]   owner_o
);

    typedef struct packed {
        lk_state_e        st;
        logic [TAG_W-1:0] tag;
        logic [ID_W-1:0]  owner;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            LK_IDLE: begin
                if (start_i) begin
                    r_d.st    = LK_HELD;
                    r_d.tag   = addr_i[ADDR_W-1:OFS_W];
                    r_d.owner = id_i;
                end
            end
            LK_HELD: begin
                if (unlock_i && done_i) begin
                    r_d.st = LK_IDLE;
                end else if (unlock_i) begin
                    r_d.st = LK_DRAINING;
                end
            end
            LK_DRAINING: begin
                if (done_i) begin
                    r_d.st = LK_IDLE;
                end
            end
            default: r_d.st = LK_IDLE;
        endcase
        if (rst) begin
            r_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign held_o  = (r_q.st != LK_IDLE);
    assign tag_o   = r_q.tag;
    assign owner_o = r_q.owner;

    AST_RESET_CLEARS: assert property (@(posedge clk) $fell(rst) |-> !held_o); // R1
    AST_LOCK_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!held_o && start_i) |=> (held_o && tag_o == $past(addr_i[ADDR_W-1:OFS_W]) && owner_o == $past(id_i))); // R2
    AST_UNLOCK_ALONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == LK_HELD && !done_i) |=> held_o); // R7
    AST_DONE_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == LK_HELD && !unlock_i) |=> held_o); // R8
    AST_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == LK_DRAINING && done_i) |=> !held_o); // R8
    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        held_o |=> (!held_o || ($stable(tag_o) && $stable(owner_o)))); // R10

endmodule

// File: rtl/line_snoop_cmp.sv
module line_snoop_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 5,
    localparam int TAG_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              held_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              retry_o
);

    logic hit;

    assign hit     = (addr_i[ADDR_W-1:OFS_W] == tag_i);
    assign retry_o = valid_i && held_i && hit;

    AST_NO_SNOOP_RETRY_IDLE: assert property (@(posedge clk) disable iff (rst)
        retry_o |-> (held_i && valid_i)); // R11

endmodule

// File: rtl/owner_gate.sv
module owner_gate #(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            held_i,
    input  logic [ID_W-1:0] owner_i,
    input  logic            valid_i,
    input  logic [ID_W-1:0] id_i,
    output logic            retry_o
);

    assign retry_o = valid_i && held_i && (id_i != owner_i);

    AST_OWNER_PASSES: assert property (@(posedge clk) disable iff (rst)
        (valid_i && id_i == owner_i) |-> !retry_o); // R6

endmodule

// File: rtl/line_lock_retry.sv
module line_lock_retry #(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    parameter int LINE_BYTES = 32,
    localparam int OFS_W     = $clog2(LINE_BYTES),
    localparam int TAG_W     = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_start,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [ID_W-1:0]   lk_id,
    input  logic              lk_unlock,
    input  logic              lk_done,
    input  logic              cpu_valid,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_retry,
    input  logic              pci_valid,
    input  logic [ID_W-1:0]   pci_id,
    output logic              pci_retry,
    output logic              lock_active
);

    logic             held;
    logic [TAG_W-1:0] tag;
    logic [ID_W-1:0]  owner;

    lock_state_ctl #(.ADDR_W(ADDR_W), .ID_W(ID_W), .OFS_W(OFS_W)) u_state (
        .clk(clk), .rst(rst),
        .start_i(lk_start), .addr_i(lk_addr), .id_i(lk_id),
        .unlock_i(lk_unlock), .done_i(lk_done),
        .held_o(held), .tag_o(tag), .owner_o(owner)
    );

    line_snoop_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_snoop (
        .clk(clk), .rst(rst), .held_i(held), .tag_i(tag),
        .valid_i(cpu_valid), .addr_i(cpu_addr), .retry_o(cpu_retry)
    );

    owner_gate #(.ID_W(ID_W)) u_owner (
        .clk(clk), .rst(rst), .held_i(held), .owner_i(owner),
        .valid_i(pci_valid), .id_i(pci_id), .retry_o(pci_retry)
    );

    assign lock_active = held;

    AST_PCI_RETRY_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        pci_retry |-> lock_active); // R11
    AST_FOREIGN_RETRIED: assert property (@(posedge clk) disable iff (rst)
        (pci_valid && lock_active && pci_id != owner) |-> pci_retry); // R5

endmodule

// File: tb/line_lock_retry_tb.sv
`timescale 1ns/100ps
module line_lock_retry_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_start, lk_unlock, lk_done, cpu_valid, pci_valid;
    logic [31:0] lk_addr, cpu_addr;
    logic [3:0]  lk_id, pci_id;
    logic        cpu_retry, pci_retry, lock_active;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    line_lock_retry u_dut (
        .clk(clk), .rst(rst), .lk_start(lk_start), .lk_addr(lk_addr), .lk_id(lk_id),
        .lk_unlock(lk_unlock), .lk_done(lk_done), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_retry(cpu_retry), .pci_valid(pci_valid), .pci_id(pci_id), .pci_retry(pci_retry),
        .lock_active(lock_active)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #0.5;
    endtask

    task automatic cpu_probe(input logic [31:0] a, input logic exp, input string req);
        cpu_valid = 1'b1; cpu_addr = a;
        #0.5;
        chk(req, cpu_retry, exp);
        cpu_valid = 1'b0;
    endtask

    task automatic pci_probe(input logic [3:0] id, input logic exp, input string req);
        pci_valid = 1'b1; pci_id = id;
        #0.5;
        chk(req, pci_retry, exp);
        pci_valid = 1'b0;
    endtask

    task automatic pulse(input logic s, input logic u, input logic d,
                         input logic [31:0] a, input logic [3:0] id);
        lk_start = s; lk_unlock = u; lk_done = d; lk_addr = a; lk_id = id;
        edge_step();
        lk_start = 1'b0; lk_unlock = 1'b0; lk_done = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        edge_step(); edge_step();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        pulse(1'b1, 1'b0, 1'b0, 32'h40, 4'd2);
        do_reset();
        chk("R1 lock_active", lock_active, 1'b0);
        cpu_probe(32'h40, 1'b0, "R1 cpu_retry");
        pci_probe(4'd9, 1'b0, "R1 pci_retry");
    endtask

    task automatic t_idle();
        cpu_probe(32'h0000_0020, 1'b0, "R11 cpu idle");
        cpu_probe(32'hFFFF_FFE0, 1'b0, "R11 cpu idle high");
        pci_probe(4'd7, 1'b0, "R11 pci idle");
    endtask

    task automatic t_lock_and_snoop();
        pulse(1'b1, 1'b0, 1'b0, 32'h0000_0028, 4'd3);
        chk("R2 lock_active", lock_active, 1'b1);
        cpu_probe(32'h0000_0020, 1'b1, "R3 line base");
        cpu_probe(32'h0000_0028, 1'b1, "R3 lock addr");
        cpu_probe(32'h0000_003F, 1'b1, "R3 line top");
        cpu_probe(32'h0000_0040, 1'b0, "R4 next line");
        cpu_probe(32'h0000_001F, 1'b0, "R4 prev line");
        cpu_probe(32'h8000_0020, 1'b0, "R4 high bit differs");
        cpu_valid = 1'b0; cpu_addr = 32'h20;
        #0.5;
        chk("R4 no strobe", cpu_retry, 1'b0);
        pci_probe(4'd5, 1'b1, "R5 foreign");
        pci_probe(4'd0, 1'b1, "R5 foreign id0");
        pci_probe(4'd3, 1'b0, "R6 owner");
        pci_valid = 1'b0; pci_id = 4'd5;
        #0.5;
        chk("R5 no strobe", pci_retry, 1'b0);
    endtask

    task automatic t_relock_ignored();
        pulse(1'b1, 1'b0, 1'b0, 32'h0000_0100, 4'd5);
        chk("R10 still held", lock_active, 1'b1);
        cpu_probe(32'h0000_0100, 1'b0, "R10 new line ignored");
        cpu_probe(32'h0000_0024, 1'b1, "R10 old line kept");
        pci_probe(4'd3, 1'b0, "R10 old owner kept");
        pci_probe(4'd5, 1'b1, "R10 new id not owner");
    endtask

    task automatic t_release_order();
        pulse(1'b0, 1'b0, 1'b1, 32'h0, 4'd0);
        chk("R8 done without unlock", lock_active, 1'b1);
        cpu_probe(32'h0000_0030, 1'b1, "R8 still snooping");
        pulse(1'b0, 1'b1, 1'b0, 32'h0, 4'd0);
        chk("R7 unlock alone", lock_active, 1'b1);
        cpu_probe(32'h0000_0030, 1'b1, "R7 cpu retry pending");
        pci_probe(4'd6, 1'b1, "R7 pci retry pending");
        edge_step();
        chk("R7 pending persists", lock_active, 1'b1);
        pulse(1'b0, 1'b0, 1'b1, 32'h0, 4'd0);
        chk("R8 released", lock_active, 1'b0);
        cpu_probe(32'h0000_0030, 1'b0, "R8 no retry after release");
        pci_probe(4'd6, 1'b0, "R8 pci free after release");
    endtask

    task automatic t_same_cycle();
        pulse(1'b1, 1'b0, 1'b0, 32'h1234_5677, 4'd1);
        chk("R2 second lock", lock_active, 1'b1);
        cpu_probe(32'h1234_5660, 1'b1, "R3 second line");
        pulse(1'b0, 1'b1, 1'b1, 32'h0, 4'd0);
        chk("R9 joint release", lock_active, 1'b0);
        cpu_probe(32'h1234_5660, 1'b0, "R9 no retry");
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        lk_start = 0; lk_unlock = 0; lk_done = 0; lk_addr = '0; lk_id = '0;
        cpu_valid = 0; cpu_addr = '0; pci_valid = 0; pci_id = '0; rst = 1'b1;
        do_reset();
        chk("R1 initial", lock_active, 1'b0);
        t_idle();
        t_lock_and_snoop();
        t_relock_ignored();
        t_release_order();
        t_same_cycle();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule